// File: doc/BRIEF.md
# Variable-Length Packet Checksum Verifier

This block sits behind the byte deserializer of a clocked serial peripheral bus. It takes one byte per strobe and files each byte into a packet buffer: receiver address, transmitter address, two command bytes, and up to nine payload bytes. The two top bits of the first command byte set the packet length. While the bytes arrive, the block keeps running modulo-256 sums and compares them against the checksum bytes carried in the packet. At the end it raises a one-cycle completion pulse together with a verdict flag.

Downstream command decoding should act on a packet only when the completion pulse is high and the verdict flag is set, because a checksum failure must suppress any parsing or reply. A separate abort input lets the bit-level receiver resynchronise the block after a framing upset. The next byte after an abort is always taken as a receiver address.

Top module: `pkt_sum_check`

## Requirements
- R1: After reset, pktDone and sumOk are 0 and every buffered field (rxAddr, txAddr, cmd1, cmd2, dataOut) reads zero.
- R2: The first four bytes of a packet land in rxAddr, txAddr, cmd1 and cmd2 in that order. The fifth byte is the header checksum.
- R3: When cmd1 bit 7 is 0, the packet is short: six bytes (four header bytes, header checksum, one closing byte). cmd1 bit 6 is then irrelevant, and the value of the closing byte is never checked.
- R4: When cmd1 bits 7:6 are 10, the packet is medium: eleven bytes, with four payload bytes in dataOut slots 0 to 3 (slot k at bits 8k+7:8k), then a payload checksum, then a closing byte.
- R5: When cmd1 bits 7:6 are 11, the packet is long: sixteen bytes, with nine payload bytes in slots 0 to 8, then a payload checksum, then a closing byte.
- R6: The header checksum must equal the modulo-256 sum of the four header bytes. Otherwise sumOk is 0 for that packet.
- R7: For medium and long packets, the payload checksum must equal the received header checksum plus all payload bytes, modulo 256. Otherwise sumOk is 0.
- R8: A short packet's verdict depends on the header checksum alone.
- R9: pktDone is high for exactly one cycle, the cycle after the closing byte is strobed. sumOk takes that packet's verdict in the same cycle and holds it until the next pktDone.
- R10: abortIn returns the block to the receiver-address position. A byte strobed in the same cycle as abortIn is discarded, and an abort that coincides with a closing byte suppresses pktDone.
- R11: Payload slots that the current packet does not carry read zero from the cycle after its first byte.
- R12: While byteValid is 0, byteData has no effect. Idle cycles between bytes of a packet leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Strobe: byteData holds a received byte |
| byteData | input | 8 | Received byte |
| abortIn | input | 1 | Resynchronise to the packet start |
| rxAddr | output | 8 | Buffered receiver address |
| txAddr | output | 8 | Buffered transmitter address |
| cmd1 | output | 8 | Buffered first command byte |
| cmd2 | output | 8 | Buffered second command byte |
| dataOut | output | 72 | Payload slots, slot k at bits 8k+7:8k |
| pktDone | output | 1 | One-cycle packet completion pulse |
| sumOk | output | 1 | Checksum verdict of the last completed packet |

## Verification
Two things can meet in one cycle: the abort and the strobe of a closing byte, or the abort and a byte in the middle of a packet. The bench drives abortIn high on the same negative edge as a strobed byte, once on the closing byte of a short packet and once at a header position. It then sends a clean packet. It judges the outcome through the scoreboard. No completion may surface for the aborted packet, and the clean packet that follows must decode with the right fields and verdict. Either failure would show up as a surplus pulse, a missing pulse, or a field mismatch.

// File: rtl/pkt_sum_pkg.sv
package pkt_sum_pkg;
  localparam int HDR_LEN   = 5;  // four header bytes plus header checksum
  localparam int MED_DATA  = 4;
  localparam int LONG_DATA = 9;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = $clog2(HDR_LEN + LONG_DATA + 2);
  localparam int SLOT_W    = $clog2(LONG_DATA);
  localparam int DATA_W    = LONG_DATA * BYTE_W;

  typedef struct packed {
    logic              take;
    logic [IDX_W-1:0]  idx;
    logic              isP1;
    logic              isData;
    logic [SLOT_W-1:0] slot;
    logic              isP2;
    logic              isLast;
    logic              hasData;
  } strobeT;
endpackage

// File: rtl/pkt_sum_ctrl.sv
module pkt_sum_ctrl
  import pkt_sum_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic       abortIn,
  input  logic [1:0] lenBits,
  output strobeT     stb,
  output logic       pktDone
);
  localparam logic [IDX_W-1:0] P1_POS   = IDX_W'(HDR_LEN - 1);
  localparam logic [IDX_W-1:0] DATA_POS = IDX_W'(HDR_LEN);
  localparam logic [IDX_W-1:0] MED_CNT  = IDX_W'(MED_DATA);
  localparam logic [IDX_W-1:0] LONG_CNT = IDX_W'(LONG_DATA);

  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] dataCnt;
  logic [IDX_W-1:0] p2Pos;
  logic [IDX_W-1:0] lastPos;
  logic [IDX_W-1:0] slotFull;
  logic             hasData;
  logic             doneQ;

  always_comb begin
    hasData  = lenBits[1];
    dataCnt  = !lenBits[1] ? '0 : (lenBits[0] ? LONG_CNT : MED_CNT);
    p2Pos    = DATA_POS + dataCnt;
    lastPos  = hasData ? p2Pos + IDX_W'(1) : DATA_POS;
    slotFull = idxQ - DATA_POS;

    stb.take    = byteValid && !abortIn;
    stb.idx     = idxQ;
    stb.isP1    = (idxQ == P1_POS);
    stb.isData  = hasData && (idxQ >= DATA_POS) && (idxQ < p2Pos);
    stb.slot    = slotFull[SLOT_W-1:0];
    stb.isP2    = hasData && (idxQ == p2Pos);
    stb.isLast  = (idxQ == lastPos);
    stb.hasData = hasData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= stb.take && stb.isLast;
      if (abortIn)
        idxQ <= '0;
      else if (stb.take)
        idxQ <= stb.isLast ? '0 : idxQ + IDX_W'(1);
    end
  end

  assign pktDone = doneQ;
endmodule

// File: rtl/pkt_sum_dp.sv
module pkt_sum_dp
  import pkt_sum_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [BYTE_W-1:0] byteData,
  output logic [BYTE_W-1:0] rxAddr,
  output logic [BYTE_W-1:0] txAddr,
  output logic [BYTE_W-1:0] cmd1,
  output logic [BYTE_W-1:0] cmd2,
  output logic [DATA_W-1:0] dataOut,
  output logic              sumOk
);
  logic [BYTE_W-1:0] rxQ, txQ, c1Q, c2Q;
  logic [BYTE_W-1:0] sum1Q, sum2Q;
  logic              p1OkQ, p2OkQ, sumOkQ;
  logic              firstByte;

  assign firstByte = stb.take && (stb.idx == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxQ    <= '0;
      txQ    <= '0;
      c1Q    <= '0;
      c2Q    <= '0;
      sum1Q  <= '0;
      sum2Q  <= '0;
      p1OkQ  <= 1'b0;
      p2OkQ  <= 1'b0;
      sumOkQ <= 1'b0;
    end else if (stb.take) begin
      case (stb.idx)
        IDX_W'(0): begin
          rxQ   <= byteData;
          sum1Q <= byteData;
          p1OkQ <= 1'b0;
          p2OkQ <= 1'b0;
        end
        IDX_W'(1): begin txQ <= byteData; sum1Q <= sum1Q + byteData; end
        IDX_W'(2): begin c1Q <= byteData; sum1Q <= sum1Q + byteData; end
        IDX_W'(3): begin c2Q <= byteData; sum1Q <= sum1Q + byteData; end
        default: ;
      endcase
      if (stb.isP1) begin
        p1OkQ <= (byteData == sum1Q);
        sum2Q <= byteData;
      end
      if (stb.isData)
        sum2Q <= sum2Q + byteData;
      if (stb.isP2)
        p2OkQ <= (byteData == sum2Q);
      if (stb.isLast)
        sumOkQ <= p1OkQ && (!stb.hasData || p2OkQ);
    end
  end

  for (genvar g = 0; g < LONG_DATA; g++) begin : gSlot
    logic [BYTE_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN || firstByte)
        slotQ <= '0;
      else if (stb.take && stb.isData && (stb.slot == SLOT_W'(g)))
        slotQ <= byteData;
    end
    assign dataOut[g*BYTE_W +: BYTE_W] = slotQ;
  end

  assign rxAddr = rxQ;
  assign txAddr = txQ;
  assign cmd1   = c1Q;
  assign cmd2   = c2Q;
  assign sumOk  = sumOkQ;
endmodule

// File: rtl/pkt_sum_check.sv
module pkt_sum_check
  import pkt_sum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  input  logic        abortIn,
  output logic [7:0]  rxAddr,
  output logic [7:0]  txAddr,
  output logic [7:0]  cmd1,
  output logic [7:0]  cmd2,
  output logic [71:0] dataOut,
  output logic        pktDone,
  output logic        sumOk
);
  strobeT stb;

  pkt_sum_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .abortIn   (abortIn),
    .lenBits   (cmd1[7:6]),
    .stb       (stb),
    .pktDone   (pktDone)
  );

  pkt_sum_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .byteData (byteData),
    .rxAddr   (rxAddr),
    .txAddr   (txAddr),
    .cmd1     (cmd1),
    .cmd2     (cmd2),
    .dataOut  (dataOut),
    .sumOk    (sumOk)
  );
endmodule

// File: rtl/pkt_sum_check_chk.sv
module pkt_sum_check_chk (
  input logic        clk,
  input logic        rstN,
  input logic        byteValid,
  input logic        abortIn,
  input logic [7:0]  rxAddr,
  input logic [7:0]  txAddr,
  input logic [7:0]  cmd1,
  input logic [7:0]  cmd2,
  input logic [71:0] dataOut,
  input logic        pktDone,
  input logic        sumOk
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

  a_r9_verdict_moves_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sumOk) |-> pktDone);

  a_r10_abort_blocks_done: assert property (@(posedge clk) disable iff (!rstN)
    abortIn |=> !pktDone);

  a_r12_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> ($stable(rxAddr) && $stable(txAddr) && $stable(cmd1)
                    && $stable(cmd2) && $stable(dataOut)));

  a_r11_short_no_payload: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && !cmd1[7]) |-> (dataOut == '0));

  a_r4_medium_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (pktDone && cmd1[7:6] == 2'b10) |-> (dataOut[71:32] == '0));
endmodule

bind pkt_sum_check pkt_sum_check_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .byteValid (byteValid),
  .abortIn   (abortIn),
  .rxAddr    (rxAddr),
  .txAddr    (txAddr),
  .cmd1      (cmd1),
  .cmd2      (cmd2),
  .dataOut   (dataOut),
  .pktDone   (pktDone),
  .sumOk     (sumOk)
);

// File: tb/pkt_sum_check_tb_top.sv
module pkt_sum_check_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        abortIn = 1'b0;
  logic [7:0]  rxAddr, txAddr, cmd1, cmd2;
  logic [71:0] dataOut;
  logic        pktDone, sumOk;

  int checks = 0;
  int fails  = 0;
  bit summaryDone = 0;
  bit prevDone = 0;

  typedef struct {
    logic [7:0]  rx, tx, c1, c2;
    logic [71:0] data;
    logic        ok;
  } expT;
  expT expQ[$];

  always #2 clk = ~clk;

  pkt_sum_check dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .abortIn(abortIn), .rxAddr(rxAddr), .txAddr(txAddr), .cmd1(cmd1),
    .cmd2(cmd2), .dataOut(dataOut), .pktDone(pktDone), .sumOk(sumOk)
  );

  task automatic checkEq(input string tag, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // Monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (pktDone) begin
        if (prevDone) begin
          checks++; fails++;
          $display("FAIL R9 pktDone wide actual=1 expected=0");
        end
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL R10 unexpected pktDone actual=1 expected=0");
        end else begin
          expT e;
          e = expQ.pop_front();
          checkEq("R2 rxAddr", {64'd0, rxAddr}, {64'd0, e.rx});
          checkEq("R2 txAddr", {64'd0, txAddr}, {64'd0, e.tx});
          checkEq("R2 cmd1",   {64'd0, cmd1},   {64'd0, e.c1});
          checkEq("R2 cmd2",   {64'd0, cmd2},   {64'd0, e.c2});
          checkEq("R4/R5/R11 dataOut", dataOut, e.data);
          checkEq("R6/R7/R8 sumOk", {71'd0, sumOk}, {71'd0, e.ok});
        end
      end
      prevDone = pktDone;
    end
  end

  task automatic putByte(input logic [7:0] v, input logic ab, input int gap);
    byteValid = 1'b1;
    byteData  = v;
    abortIn   = ab;
    @(negedge clk);
    byteValid = 1'b0;
    abortIn   = 1'b0;
    byteData  = 8'($urandom);  // R12: noise while no strobe
    repeat (gap) begin
      byteData = 8'($urandom);
      @(negedge clk);
    end
  endtask

  // Driver: build a packet, push its expected result, send it
  task automatic sendPkt(input logic [7:0] rx, input logic [7:0] tx,
                         input logic [7:0] c1, input logic [7:0] c2,
                         input logic [71:0] d, input bit badP1,
                         input bit badP2, input int gap);
    int n;
    logic [7:0] p1, p2;
    expT e;
    n  = !c1[7] ? 0 : (c1[6] ? 9 : 4);
    p1 = rx + tx + c1 + c2 + (badP1 ? 8'd1 : 8'd0);
    p2 = p1;
    e.data = '0;
    for (int k = 0; k < n; k++) begin
      p2 = p2 + d[k*8 +: 8];
      e.data[k*8 +: 8] = d[k*8 +: 8];
    end
    if (badP2) p2 = p2 + 8'd1;
    e.rx = rx; e.tx = tx; e.c1 = c1; e.c2 = c2;
    e.ok = !badP1 && !(n > 0 && badP2);
    expQ.push_back(e);
    putByte(rx, 0, gap); putByte(tx, 0, gap);
    putByte(c1, 0, gap); putByte(c2, 0, gap);
    putByte(p1, 0, gap);
    for (int k = 0; k < n; k++) putByte(d[k*8 +: 8], 0, gap);
    if (n > 0) putByte(p2, 0, gap);
    putByte(8'h00, 0, gap);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [71:0] pay;
    pay = 72'h99_88_77_66_55_44_33_22_11;
    repeat (4) @(negedge clk);
    // R1: reset state
    checkEq("R1 pktDone", {71'd0, pktDone}, 72'd0);
    checkEq("R1 sumOk",   {71'd0, sumOk},   72'd0);
    checkEq("R1 rxAddr",  {64'd0, rxAddr},  72'd0);
    checkEq("R1 dataOut", dataOut, 72'd0);
    rstN = 1'b1;
    idle(2);

    // R3/R8: short packets, good and with header sum error (R6)
    sendPkt(8'h10, 8'hD0, 8'h01, 8'h02, pay, 0, 0, 0);
    idle(3);
    sendPkt(8'h20, 8'h30, 8'h41, 8'h12, pay, 1, 0, 0);
    idle(3);
    checkEq("R9 sumOk held after bad packet", {71'd0, sumOk}, 72'd0);
    // R6: mod-256 wrap of the header sum
    sendPkt(8'hFF, 8'hFF, 8'h7F, 8'hFE, pay, 0, 0, 1);
    idle(3);
    checkEq("R9 sumOk held after good packet", {71'd0, sumOk}, 72'd1);

    // R4/R12: medium with gaps; R7 payload sum error; R6 header error
    sendPkt(8'h18, 8'h10, 8'h87, 8'h2A, pay, 0, 0, 2);
    idle(2);
    sendPkt(8'h18, 8'h10, 8'h87, 8'h22, pay, 0, 1, 0);
    idle(2);
    sendPkt(8'hD1, 8'h10, 8'hB0, 8'h05, pay, 1, 0, 0);
    idle(2);

    // R5: long good and long with payload sum error
    sendPkt(8'h70, 8'hD0, 8'hC4, 8'h80, 72'hFF_FE_FD_FC_FB_FA_F9_F8_F7, 0, 0, 0);
    idle(2);
    sendPkt(8'h70, 8'hD0, 8'hC0, 8'h01, pay, 0, 1, 1);
    idle(2);
    // R11: short after long leaves payload cleared
    sendPkt(8'h01, 8'h02, 8'h03, 8'h04, pay, 0, 0, 0);
    idle(2);

    // R10: abort with a header byte in the same cycle, then a clean packet
    putByte(8'h55, 0, 0); putByte(8'h66, 0, 0); putByte(8'h77, 1, 0);
    sendPkt(8'h31, 8'h32, 8'h03, 8'h34, pay, 0, 0, 0);
    idle(2);
    // R10: abort coincides with the closing byte of a short packet
    putByte(8'h40, 0, 0); putByte(8'h41, 0, 0); putByte(8'h02, 0, 0);
    putByte(8'h43, 0, 0); putByte(8'hC6, 0, 0); putByte(8'h00, 1, 0);
    idle(3);
    sendPkt(8'h18, 8'h10, 8'h80, 8'h00, pay, 0, 0, 0);
    idle(4);

    // R3/R10: every expected completion was seen, none left over
    checkEq("R3 R10 scoreboard drained", 72'(expQ.size()), 72'd0);
    finishRun();
  end
endmodule